// File: doc/BRIEF.md
# Recency Age Tracker for Cache Replacement

This block keeps one recency age per slot of a small fully associative cache. The ages always form a permutation of 0 to N-1. The largest value marks the slot used most recently, and 0 marks the slot used least recently. When the cache hits or fills a slot, it strobes that slot's index into the tracker.

On a strobe, the touched slot jumps to the top age. Every slot that was fresher than it moves down by one, and the older slots keep their ages, so no two slots ever share an age. The slot that holds age 0 is always reported as the replacement victim. A set-associative cache can place one tracker in each set. The tracker holds no tags, no data and no memory interface.

Top module: `lru_age_tracker`

## Requirements
- R1: After reset, slot i holds age i. For the default of 7 slots, the ages are 0,1,2,3,4,5,6 and the victim is slot 0.
- R2: A valid strobe with an in-range index sets the touched slot's age to N-1 at the next clock edge.
- R3: On a valid strobe, every other slot whose age was greater than the touched slot's old age is decremented by one. For example, from ages 0..6, touching slot 3 gives 0,1,2,6,3,4,5.
- R4: On a valid strobe, every slot whose age was less than the touched slot's old age keeps its age.
- R5: Touching the slot that already holds age N-1 leaves all ages unchanged.
- R6: `victim_slot` always equals the index of the slot whose age is 0.
- R7: While `touch_valid` is low, all ages hold their values.
- R8: A strobe whose index is N or greater is ignored and leaves all ages unchanged. For 7 slots, index 7 is ignored.
- R9: The ages always form a permutation of 0..N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| touch_valid | input | 1 | Access strobe for one cycle |
| touch_slot | input | IDX_W (3) | Index of the accessed slot |
| victim_slot | output | IDX_W (3) | Index of the slot whose age is 0 |
| ages_flat | output | NUM_SLOTS*IDX_W (21) | Age of slot i in bits [i*IDX_W +: IDX_W] |

## Verification
Ages are registered, so a strobe that is sampled at a rising edge appears on `ages_flat` right after that edge. `victim_slot` is decoded combinationally from the registered ages and changes at the same moment. The driver applies each strobe on a falling edge and pushes the ages and victim that a model predicts. The monitor pops that prediction 1 ns after the next rising edge, which is the first instant both results are due, and compares them there.

// File: rtl/lru_pkg.sv
package lru_pkg;

    // Update chosen for one slot on a clock edge
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_PROMOTE = 2'd1,
        ACT_DEMOTE  = 2'd2
    } age_act_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/lru_age_cell.sv
module lru_age_cell
    import lru_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    parameter int SLOT_ID   = 0,
    localparam int IDX_W    = idx_width(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_ok,
    input  logic [IDX_W-1:0] touch_slot,
    input  logic [IDX_W-1:0] touched_age,
    output logic [IDX_W-1:0] age
);

    localparam logic [IDX_W-1:0] AGE_TOP   = IDX_W'(NUM_SLOTS - 1);
    localparam logic [IDX_W-1:0] AGE_RESET = IDX_W'(SLOT_ID);
    localparam logic [IDX_W-1:0] MY_ID     = IDX_W'(SLOT_ID);

    age_act_e act;

    always_comb begin
        act = ACT_HOLD;
        if (touch_ok) begin
            if (touch_slot == MY_ID) begin
                act = ACT_PROMOTE;
            end else if (age > touched_age) begin
                act = ACT_DEMOTE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= AGE_RESET;
        end else begin
            unique case (act)
                ACT_PROMOTE: age <= AGE_TOP;
                ACT_DEMOTE:  age <= age - 1'b1;
                default:     age <= age;
            endcase
        end
    end

endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel
    import lru_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    localparam int IDX_W    = idx_width(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS*IDX_W-1:0] ages_flat,
    output logic [IDX_W-1:0]           victim_slot
);

    // Exactly one slot is at age 0, so OR-merging the matching indices is exact
    always_comb begin
        victim_slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (ages_flat[i*IDX_W +: IDX_W] == '0) begin
                victim_slot = victim_slot | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker
    import lru_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    localparam int IDX_W    = idx_width(NUM_SLOTS),
    localparam int FLAT_W   = NUM_SLOTS * IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch_valid,
    input  logic [IDX_W-1:0]  touch_slot,
    output logic [IDX_W-1:0]  victim_slot,
    output logic [FLAT_W-1:0] ages_flat
);

    logic             touch_ok;
    logic [IDX_W-1:0] touched_age;

    assign touch_ok = touch_valid && (int'(touch_slot) < NUM_SLOTS);

    // Read the touched slot's age before the edge
    always_comb begin
        touched_age = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (int'(touch_slot) == i) begin
                touched_age = ages_flat[i*IDX_W +: IDX_W];
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cell
        lru_age_cell #(
            .NUM_SLOTS (NUM_SLOTS),
            .SLOT_ID   (g)
        ) cell_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .touch_ok    (touch_ok),
            .touch_slot  (touch_slot),
            .touched_age (touched_age),
            .age         (ages_flat[g*IDX_W +: IDX_W])
        );
    end

    lru_victim_sel #(
        .NUM_SLOTS (NUM_SLOTS)
    ) vsel_i (
        .ages_flat   (ages_flat),
        .victim_slot (victim_slot)
    );

endmodule

// File: rtl/lru_age_tracker_chk.sv
module lru_age_tracker_chk
    import lru_pkg::*;
#(
    parameter int NUM_SLOTS = 7,
    localparam int IDX_W    = idx_width(NUM_SLOTS),
    localparam int FLAT_W   = NUM_SLOTS * IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              touch_valid,
    input logic [IDX_W-1:0]  touch_slot,
    input logic [IDX_W-1:0]  victim_slot,
    input logic [FLAT_W-1:0] ages_flat
);

    localparam logic [IDX_W-1:0] AGE_TOP = IDX_W'(NUM_SLOTS - 1);

    logic [NUM_SLOTS-1:0] seen;
    logic                 perm_ok;
    logic                 in_range;
    logic [IDX_W-1:0]     cur_age;

    always_comb begin
        seen    = '0;
        perm_ok = 1'b1;
        cur_age = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (int'(ages_flat[i*IDX_W +: IDX_W]) >= NUM_SLOTS) begin
                perm_ok = 1'b0;
            end else begin
                seen[ages_flat[i*IDX_W +: IDX_W]] = 1'b1;
            end
            if (int'(touch_slot) == i) begin
                cur_age = ages_flat[i*IDX_W +: IDX_W];
            end
        end
        if (!(&seen)) begin
            perm_ok = 1'b0;
        end
    end

    assign in_range = int'(touch_slot) < NUM_SLOTS;

    p_permutation_r9: assert property (@(posedge clk) disable iff (!rst_n)
        perm_ok);

    p_victim_age_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ages_flat[victim_slot*IDX_W +: IDX_W] == '0);

    p_touch_to_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_valid && in_range) |=>
            ages_flat[$past(touch_slot)*IDX_W +: IDX_W] == AGE_TOP);

    p_freshest_noop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_valid && in_range && cur_age == AGE_TOP) |=> $stable(ages_flat));

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_valid |=> $stable(ages_flat));

    p_bad_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_valid && !in_range) |=> $stable(ages_flat));

endmodule

bind lru_age_tracker lru_age_tracker_chk #(
    .NUM_SLOTS (NUM_SLOTS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .touch_valid (touch_valid),
    .touch_slot  (touch_slot),
    .victim_slot (victim_slot),
    .ages_flat   (ages_flat)
);

// File: tb/lru_age_tracker_tb_top.sv
`timescale 1ns/1ps
module lru_age_tracker_tb_top;

    localparam int N      = 7;
    localparam int IDX_W  = 3;
    localparam int FLAT_W = N * IDX_W;

    typedef struct {
        logic [FLAT_W-1:0] ages;
        logic [IDX_W-1:0]  victim;
        string             tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              touch_valid = 1'b0;
    logic [IDX_W-1:0]  touch_slot = '0;
    logic [IDX_W-1:0]  victim_slot;
    logic [FLAT_W-1:0] ages_flat;

    int   checks = 0;
    int   errors = 0;
    int   model [N];
    exp_t sb_q [$];
    bit   done = 1'b0;

    always #2 clk = ~clk;

    lru_age_tracker #(.NUM_SLOTS(N)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_valid (touch_valid),
        .touch_slot  (touch_slot),
        .victim_slot (victim_slot),
        .ages_flat   (ages_flat)
    );

    function automatic exp_t snapshot(input string tag);
        exp_t e;
        e.ages   = '0;
        e.victim = '0;
        e.tag    = tag;
        for (int i = 0; i < N; i++) begin
            e.ages[i*IDX_W +: IDX_W] = IDX_W'(model[i]);
            if (model[i] == 0) e.victim = IDX_W'(i);
        end
        return e;
    endfunction

    task automatic compare(input exp_t e);
        checks++;
        if (ages_flat !== e.ages) begin
            errors++;
            $display("FAIL %s ages actual=%h expected=%h", e.tag, ages_flat, e.ages);
        end
        checks++;
        if (victim_slot !== e.victim) begin
            errors++;
            $display("FAIL R6 victim actual=%0d expected=%0d", victim_slot, e.victim);
        end
    endtask

    // Driver: apply on falling edge, push the model's prediction
    task automatic drive(input bit v, input int s, input string tag);
        int old;
        @(negedge clk);
        touch_valid = v;
        touch_slot  = IDX_W'(s);
        if (v && s < N) begin
            old = model[s];
            for (int j = 0; j < N; j++) begin
                if (j == s) model[j] = N - 1;
                else if (model[j] > old) model[j] = model[j] - 1;
            end
        end
        sb_q.push_back(snapshot(tag));
    endtask

    // Monitor: result is due just after the rising edge that samples the strobe
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) compare(sb_q.pop_front());
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        for (int i = 0; i < N; i++) model[i] = i;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(snapshot("R1 reset"));

        drive(1'b0, 0, "R7 idle");
        drive(1'b1, 3, "R2 R3 R4 touch3");
        drive(1'b1, 3, "R5 freshest");
        drive(1'b0, 5, "R7 idle slot5");
        drive(1'b1, 7, "R8 bad index");
        drive(1'b1, 0, "R2 R3 touch0");
        drive(1'b1, 6, "R3 R4 touch6");
        drive(1'b1, 2, "R2 R3 R4 touch2");
        drive(1'b1, 2, "R5 repeat");

        lfsr = 8'h5B;
        for (int k = 0; k < 60; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            drive(lfsr[7], int'(lfsr[2:0]), "R9 R6 mixed");
        end
        drive(1'b0, 0, "R7 final");
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule